// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the 16-bit fetch address of a small 8-bit processor core and decides, once per clock, what that address becomes next. The address space is 64 Kbyte. The core's decoder and interrupt controller drive single-cycle request strobes:

- step to the next location;
- jump;
- call a subroutine;
- return from a subroutine;
- return from an interrupt;
- enter an interrupt.

The block resolves these strobes by a fixed priority and loads the program counter from the matching source. The sources are the sequential successor, a shared target address bus, an interrupt vector bus, the top of an internal return stack, and a reset vector constant.

Subroutine calls and interrupt entries share one hardware return-address stack of eight entries.

- A call saves the address after the current one.
- An interrupt saves the current, not yet executed address.
- Both kinds of return restore the most recently saved address.

Misuse of the stack is reported through two sticky status outputs rather than by corrupting the program counter. A push onto a full stack sets one flag. A pop from an empty stack sets the other.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the PC loads RESET_VEC (default 16'h0100), the return stack becomes empty and both status flags clear. Reset outranks every request.
- R2: With step_en high and no other request, the PC advances by one and wraps from 16'hFFFF to 16'h0000. With no request at all, the PC holds its value.
- R3: A jump request loads the PC with target_addr.
- R4: A call request pushes PC+1 (modulo 2^16) onto the return stack and loads the PC with target_addr.
- R5: An interrupt request pushes the current PC onto the return stack and loads the PC with intr_vector.
- R6: ret_req and reti_req each pop the most recently pushed address into the PC, so that nested calls and interrupts unwind in last-in, first-out order.
- R7: When several requests are high in the same cycle, exactly one is served, in this order: interrupt first, then RET or RETI, then call, then jump, then step.
- R8: A push while the stack holds DEPTH entries (default 8) discards the pushed address, leaves the stored entries intact and sets stack_overflow. The PC still loads the new address.
- R9: A pop while the stack is empty sets stack_underflow and leaves the PC unchanged.
- R10: Once set, stack_overflow and stack_underflow stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance to the next sequential address |
| jump_req | input | 1 | Load target_addr |
| call_req | input | 1 | Save the return address, then load target_addr |
| ret_req | input | 1 | Return from subroutine (pop) |
| reti_req | input | 1 | Return from interrupt (pop) |
| intr_req | input | 1 | Accept an interrupt: save the current PC, then load intr_vector |
| target_addr | input | 16 | Jump or call destination |
| intr_vector | input | 16 | Interrupt service entry address |
| pc | output | 16 | Current program counter |
| stack_overflow | output | 1 | Sticky: a push found the stack full |
| stack_underflow | output | 1 | Sticky: a pop found the stack empty |

## Verification
The assertions assume that every request strobe and both address buses carry known values at each rising edge. They also assume that a request is a level sampled at that edge, with no hold-over into the next cycle. The stimulus meets both assumptions:

- it changes every input only on the falling edge;
- it always drives full 16-bit addresses;
- it never leaves a strobe undriven.

The priority sweep applies a fresh reset and a single preparatory call before each of the 64 request combinations. This means each combination starts from a known PC and a known stack depth.

// File: rtl/pcseq_pkg.sv
// Package pcseq_pkg
// Shared types for the program counter sequencer: the operation chosen for a
// cycle after priority resolution. Assumes one operation per clock.
package pcseq_pkg;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_STEP   = 3'd1,
        OP_JUMP   = 3'd2,
        OP_CALL   = 3'd3,
        OP_RETURN = 3'd4,
        OP_INTR   = 3'd5
    } pc_op_e;

endpackage

// File: rtl/pcseq_arbiter.sv
// Module pcseq_arbiter
// Collapses the request strobes into a single operation by fixed priority:
// interrupt, return (either kind), call, jump, step, else hold.
// Assumes strobes are sampled levels; reset priority is handled by the owner.
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    input  logic   jump_req,
    input  logic   call_req,
    input  logic   ret_req,
    input  logic   reti_req,
    input  logic   intr_req,
    output pc_op_e op
);

    // Priority encoder: the first request found in priority order wins.
    always_comb begin
        if (intr_req)                op = OP_INTR;
        else if (ret_req || reti_req) op = OP_RETURN;
        else if (call_req)           op = OP_CALL;
        else if (jump_req)           op = OP_JUMP;
        else if (step_en)            op = OP_STEP;
        else                         op = OP_HOLD;
    end

    AST_INTR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req |-> op == OP_INTR);                                   // R7
    AST_RETURN_BEATS_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!intr_req && (ret_req || reti_req)) |-> op == OP_RETURN);     // R7

endmodule

// File: rtl/pcseq_stack.sv
// Module pcseq_stack
// Return-address LIFO of DEPTH entries with sticky overflow and underflow
// flags. A push when full is dropped; a pop when empty leaves the depth at 0.
// Assumes push and pop are never high together (the arbiter guarantees it).
module pcseq_stack #(
    parameter int AW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] top,
    output logic          empty,
    output logic          full,
    output logic          overflow,
    output logic          underflow
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    logic [AW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    // Index decode: write at the current depth, read one below it.
    always_comb begin
        wr_idx = IW'(cnt);
        rd_idx = IW'(cnt - CW'(1));
        empty  = (cnt == '0);
        full   = (cnt == CNT_MAX);
        top    = mem[rd_idx];
    end

    // Storage write; entries are left untouched on a dropped push.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_idx] <= push_data;
    end

    // Depth counter and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (push) begin
                if (full) overflow <= 1'b1;
                else      cnt      <= cnt + CW'(1);
            end else if (pop) begin
                if (empty) underflow <= 1'b1;
                else       cnt       <= cnt - CW'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);                                               // R8
    AST_FULL_PUSH_HOLDS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> full && overflow);                          // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                        // R10
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);                                      // R10

endmodule

// File: rtl/pcseq_nextpc.sv
// Module pcseq_nextpc
// Computes the next program counter and the stack command for the selected
// operation. Purely combinational; assumes stk_top is valid when not empty.
module pcseq_nextpc
    import pcseq_pkg::*;
#(
    parameter int AW = 16
) (
    input  pc_op_e        op,
    input  logic [AW-1:0] pc_cur,
    input  logic [AW-1:0] target_addr,
    input  logic [AW-1:0] intr_vector,
    input  logic [AW-1:0] stk_top,
    input  logic          stk_empty,
    output logic [AW-1:0] pc_next,
    output logic          push,
    output logic [AW-1:0] push_data,
    output logic          pop
);

    logic [AW-1:0] pc_inc;

    // Sequential successor, wrapping at the top of the address space.
    always_comb pc_inc = pc_cur + AW'(1);

    // Source select for the next address and the matching stack action.
    always_comb begin
        pc_next   = pc_cur;
        push      = 1'b0;
        push_data = pc_inc;
        pop       = 1'b0;
        unique case (op)
            OP_STEP:   pc_next = pc_inc;
            OP_JUMP:   pc_next = target_addr;
            OP_CALL: begin
                push      = 1'b1;
                push_data = pc_inc;
                pc_next   = target_addr;
            end
            OP_INTR: begin
                push      = 1'b1;
                push_data = pc_cur;
                pc_next   = intr_vector;
            end
            OP_RETURN: begin
                pop     = 1'b1;
                pc_next = stk_empty ? pc_cur : stk_top;
            end
            default:   pc_next = pc_cur;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
// Module pc_sequencer
// Top of the program counter sequencer: priority arbiter, next-address
// logic, return stack and the PC register. Assumes synchronous active-low
// reset and request strobes that are valid levels at each rising edge.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int            AW        = 16,
    parameter int            DEPTH     = 8,
    parameter logic [AW-1:0] RESET_VEC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          jump_req,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic          reti_req,
    input  logic          intr_req,
    input  logic [AW-1:0] target_addr,
    input  logic [AW-1:0] intr_vector,
    output logic [AW-1:0] pc,
    output logic          stack_overflow,
    output logic          stack_underflow
);

    pc_op_e        op;
    logic [AW-1:0] pc_next;
    logic          push;
    logic [AW-1:0] push_data;
    logic          pop;
    logic [AW-1:0] stk_top;
    logic          stk_empty;
    logic          stk_full;

    pcseq_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .jump_req (jump_req),
        .call_req (call_req),
        .ret_req  (ret_req),
        .reti_req (reti_req),
        .intr_req (intr_req),
        .op       (op)
    );

    pcseq_nextpc #(.AW(AW)) u_next (
        .op          (op),
        .pc_cur      (pc),
        .target_addr (target_addr),
        .intr_vector (intr_vector),
        .stk_top     (stk_top),
        .stk_empty   (stk_empty),
        .pc_next     (pc_next),
        .push        (push),
        .push_data   (push_data),
        .pop         (pop)
    );

    pcseq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .top       (stk_top),
        .empty     (stk_empty),
        .full      (stk_full),
        .overflow  (stack_overflow),
        .underflow (stack_underflow)
    );

    // Program counter register; reset outranks every request.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_VEC;
        else        pc <= pc_next;
    end

    AST_RESET_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pc == RESET_VEC && !stack_overflow && !stack_underflow)); // R1
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_STEP |=> pc == AW'($past(pc) + AW'(1)));              // R2
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_JUMP |=> pc == $past(target_addr));                   // R3
    AST_INTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_INTR |=> pc == $past(intr_vector));                   // R5
    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RETURN && stk_empty) |=> ($stable(pc) && stack_underflow)); // R9
    AST_CALL_FULL_STILL_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL && stk_full) |=> pc == $past(target_addr));     // R8

endmodule

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;

    localparam logic [15:0] RV = 16'h0100;
    localparam int          SD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 0, jump_req = 0, call_req = 0;
    logic        ret_req = 0, reti_req = 0, intr_req = 0;
    logic [15:0] target_addr = '0, intr_vector = '0;
    logic [15:0] pc;
    logic        stack_overflow, stack_underflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state derived from the requirements.
    logic [15:0] m_pc;
    logic [15:0] m_stk [SD];
    int          m_cnt;
    bit          m_ovf, m_unf;

    always #5 clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_req(jump_req),
        .call_req(call_req), .ret_req(ret_req), .reti_req(reti_req),
        .intr_req(intr_req), .target_addr(target_addr), .intr_vector(intr_vector),
        .pc(pc), .stack_overflow(stack_overflow), .stack_underflow(stack_underflow)
    );

    task automatic compare(input string tag);
        checks++;
        if (pc !== m_pc) begin
            errors++;
            $display("FAIL %s pc actual=%h expected=%h", tag, pc, m_pc);
        end
        checks++;
        if (stack_overflow !== m_ovf || stack_underflow !== m_unf) begin
            errors++;
            $display("FAIL %s flags actual=%b%b expected=%b%b", tag,
                     stack_overflow, stack_underflow, m_ovf, m_unf);
        end
    endtask

    task automatic m_push(input logic [15:0] v, inout string tag);
        if (m_cnt == SD) begin m_ovf = 1; tag = {tag, " R8"}; end
        else begin m_stk[m_cnt] = v; m_cnt++; end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 0; step_en = 1; call_req = 1; intr_req = 1;
        @(posedge clk); #1;
        m_pc = RV; m_cnt = 0; m_ovf = 0; m_unf = 0;
        compare({tag, " R1"});
        @(negedge clk);
        rst_n = 1; step_en = 0; call_req = 0; intr_req = 0;
    endtask

    // One cycle: drive at the falling edge, check just after the rising edge.
    task automatic cyc(input bit i, input bit r, input bit ri, input bit c,
                       input bit j, input bit s, input logic [15:0] tgt,
                       input logic [15:0] vec, input string pre);
        string tag;
        tag = pre;
        @(negedge clk);
        intr_req = i; ret_req = r; reti_req = ri; call_req = c;
        jump_req = j; step_en = s; target_addr = tgt; intr_vector = vec;
        if (i) begin tag = {tag, " R5"}; m_push(m_pc, tag); m_pc = vec; end
        else if (r || ri) begin
            tag = {tag, " R6"};
            if (m_cnt == 0) begin m_unf = 1; tag = {tag, " R9"}; end
            else begin m_cnt--; m_pc = m_stk[m_cnt]; end
        end
        else if (c) begin tag = {tag, " R4"}; m_push(m_pc + 16'd1, tag); m_pc = tgt; end
        else if (j) begin tag = {tag, " R3"}; m_pc = tgt; end
        else if (s) begin tag = {tag, " R2"}; m_pc = m_pc + 16'd1; end
        else tag = {tag, " R2 hold"};
        if (m_ovf || m_unf) tag = {tag, " R10"};
        @(posedge clk); #1;
        compare(tag);
        @(negedge clk);
        intr_req = 0; ret_req = 0; reti_req = 0; call_req = 0; jump_req = 0; step_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        do_reset("init");
        cyc(0,0,0,0,0,0,16'h1234,16'h5555,"hold");
        // Wrap-around stepping (R2) after a jump (R3).
        cyc(0,0,0,0,1,0,16'hFFFD,16'h0,"wrap");
        for (int k = 0; k < 5; k++) cyc(0,0,0,0,0,1,16'h0,16'h0,"wrap");
        // Nest calls and interrupts to full depth, then one more (R8).
        for (int k = 0; k < SD + 2; k++) begin
            if (k % 3 == 2) cyc(1,0,0,0,0,0,16'h0,16'h4000 + 16'(k * 16),"nest");
            else            cyc(0,0,0,1,0,0,16'h3000 + 16'(k * 257),16'h0,"nest");
            cyc(0,0,0,0,0,1,16'h0,16'h0,"nest");
        end
        // Unwind in LIFO order, then underflow (R9), then stickiness (R10).
        for (int k = 0; k < SD + 2; k++) cyc(0, k[0], ~k[0], 0,0,0,16'h0,16'h0,"unwind");
        cyc(0,0,0,1,0,0,16'h7777,16'h0,"sticky");
        cyc(0,1,0,0,0,0,16'h0,16'h0,"sticky");
        do_reset("clear");
        // Interrupt entry and return restores the un-executed PC (R5, R6).
        cyc(0,0,0,0,0,1,16'h0,16'h0,"irq");
        cyc(1,0,0,0,0,1,16'h0,16'hAB00,"irq");
        cyc(0,0,1,0,0,0,16'h0,16'h0,"irq");
        // Priority sweep over every request combination (R7).
        for (int m = 0; m < 64; m++) begin
            do_reset("R7 prep");
            cyc(0,0,0,1,0,0,16'h2000,16'h0,"R7 prep");
            cyc(m[5], m[4], m[3], m[2], m[1], m[0], 16'h6000 + 16'(m), 16'h8000 + 16'(m), "R7");
        end
        // Pseudo-random mix of all operations.
        do_reset("mix");
        lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[3:0] == 0, lf[6:4] == 0, lf[9:7] == 0, lf[12:10] == 0,
                lf[14:13] == 0, lf[15], {lf[7:0], lf[15:8]}, lf ^ 16'h5A5A, "mix");
            if (k % 700 == 699) do_reset("mix");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule